// File: doc/BRIEF.md
# Decimal-Capable 8-bit Add/Subtract Unit

This block is the arithmetic core of an 8-bit processor ALU. It adds with carry or subtracts with borrow, in either plain two's-complement or packed-BCD form. A two-bit selector picks which processor generation's decimal behaviour is reproduced: the original NMOS part, the later CMOS part, or the 16-bit successor running in 8-bit mode. Each generation applies its own digit-correction sequence and draws its flags from its own mix of sources. These sources are the binary operation, the uncorrected intermediate, and the corrected result.

Every one of the 256×256×2 operand and carry combinations yields a defined result that matches the chosen variant, including operands with nibbles 0xA–0xF. The datapath is combinational. A parameter places an optional register on the result and flag outputs, so the block can sit inside a pipelined execute stage.

Top module: `dec_arith_unit`

## Requirements
- R1: With `dec_i`=0 and `sub_i`=0 the result is (a+b+carry) mod 256; C is the carry out of bit 7, V is set on signed overflow, N is result bit 7 and Z is set for a zero result.
- R2: With `dec_i`=0 and `sub_i`=1 the result is (a−b−(1−carry)) mod 256; carry in 1 means no borrow, C=1 means no borrow occurred, V is set on signed overflow, and N and Z follow the result.
- R3: In decimal add, a low-digit sum (low nibbles plus carry) of 10 or more gets 6 added, is cut to 4 bits and passes a carry of 0x10 into the high digit; two valid BCD operands always give a valid BCD result (0x09+0x01 → 0x10).
- R4: In decimal add, if the high-digit intermediate carries out or reaches 0xA0, 0x60 is added and C is set; otherwise C is 0 (0x99+0x01 → 0x00 with C=1).
- R5: For variants 0 and 3, a decimal add takes N from bit 7 and V from the signed overflow of the intermediate before the 0x60 step, and takes Z from the binary sum of the same inputs.
- R6: For variants 0, 2 and 3, a decimal subtract takes a further 6 off a borrowing low digit and keeps 4 bits. It then subtracts the high digits with the borrow (0x10) and, if that borrows, takes off 0x60 (0x00−0x01 with carry 1 → 0x99).
- R7: For variant 1, a decimal subtract skips the low-digit 6 step and instead subtracts 6 from the final result whenever the low digit borrowed (0x10−0x01 with carry 1 → 0x09).
- R8: For variants 0 and 3, all four flags of a decimal subtract equal those of the binary subtract of the same inputs.
- R9: For variants 1 and 2 in decimal mode, N and Z follow the final result and V is the binary V. C is the decimal carry for add and the binary C for subtract.
- R10: Variant code 3 produces the same result and flags as variant code 0 for all inputs.
- R11: With `REG_OUT`=1 the outputs show the result for the inputs sampled at the previous rising clock edge and are all zero while `rst_ni` is low. With `REG_OUT`=0 they follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 8 | First operand (minuend for subtract) |
| b_i | input | 8 | Second operand (subtrahend for subtract) |
| carry_i | input | 1 | Carry in; for subtract 1 means no borrow |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_i | input | 1 | 1 = packed-BCD arithmetic |
| variant_i | input | 2 | 0 NMOS, 1 CMOS, 2 16-bit successor, 3 same as 0 |
| result_o | output | 8 | Result byte |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag (no-borrow for subtract) |

## Verification
The bench builds two copies: one with `REG_OUT`=1, which exposes the reset value and the one-cycle output lag, and one with `REG_OUT`=0, which is checked against the same vector within the same cycle. Both see the same random operands over every mode, direction and variant code, including invalid-BCD nibbles and both carry values. This puts the variant-specific flag sources and the corrections that differ between generations within reach. Directed vectors pin the known digit-roll cases: 0x09+0x01, 0x99+0x01, 0x10−0x01 and 0x00−0x01.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;

  typedef enum logic [1:0] {
    VAR_NMOS = 2'd0,
    VAR_CMOS = 2'd1,
    VAR_WIDE = 2'd2,
    VAR_ALT  = 2'd3
  } variant_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/dau_bin.sv
module dau_bin
  import dau_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output flags_t        flags_o
);
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, ci_i};
    res_o = sum[DW-1:0];
    flags_o.c = sum[DW];
    flags_o.n = sum[DW-1];
    flags_o.z = (sum[DW-1:0] == '0);
    flags_o.v = (a_i[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a_i[DW-1]);
  end
endmodule

// File: rtl/dau_dec_add.sv
module dau_dec_add
  import dau_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          mid_n_o,
  output logic          mid_v_o
);
  localparam logic [NW:0]   LO_LIMIT = (NW+1)'(10);
  localparam logic [NW-1:0] LO_FIX   = NW'(6);
  localparam logic [DW:0]   HI_STEP  = (DW+1)'(16);
  localparam logic [DW-1:0] HI_LIMIT = DW'(8'hA0);
  localparam logic [DW-1:0] HI_FIX   = DW'(8'h60);

  logic [NW:0]   lo_sum;
  logic          lo_adj;
  logic [NW-1:0] lo_dig;
  logic [DW:0]   mid;
  logic          hi_adj;

  always_comb begin
    lo_sum  = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, ci_i};
    lo_adj  = (lo_sum >= LO_LIMIT);
    lo_dig  = lo_adj ? (lo_sum[NW-1:0] + LO_FIX) : lo_sum[NW-1:0];
    mid     = {1'b0, a_i[DW-1:NW], lo_dig} + {1'b0, b_i[DW-1:NW], {NW{1'b0}}}
            + (lo_adj ? HI_STEP : '0);
    mid_n_o = mid[DW-1];
    mid_v_o = (a_i[DW-1] == b_i[DW-1]) && (mid[DW-1] != a_i[DW-1]);
    hi_adj  = mid[DW] || (mid[DW-1:0] >= HI_LIMIT);
    carry_o = hi_adj;
    res_o   = hi_adj ? (mid[DW-1:0] + HI_FIX) : mid[DW-1:0];
  end
endmodule

// File: rtl/dau_dec_sub.sv
module dau_dec_sub
  import dau_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  input  logic          late_fix_i,
  output logic [DW-1:0] res_o
);
  localparam logic [NW-1:0] LO_FIX  = NW'(6);
  localparam logic [DW:0]   HI_STEP = (DW+1)'(16);
  localparam logic [DW-1:0] HI_FIX  = DW'(8'h60);
  localparam logic [DW-1:0] END_FIX = DW'(6);

  logic [NW:0]   lo_diff;
  logic          lo_borrow;
  logic [NW-1:0] lo_dig;
  logic [DW:0]   mid;
  logic [DW-1:0] stage;

  always_comb begin
    lo_diff   = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - {{NW{1'b0}}, ~ci_i};
    lo_borrow = lo_diff[NW];
    // early-correcting parts fix the low digit here, the CMOS part at the end
    lo_dig    = (lo_borrow && !late_fix_i) ? (lo_diff[NW-1:0] - LO_FIX) : lo_diff[NW-1:0];
    mid       = {1'b0, a_i[DW-1:NW], lo_dig} - {1'b0, b_i[DW-1:NW], {NW{1'b0}}}
              - (lo_borrow ? HI_STEP : '0);
    stage     = mid[DW] ? (mid[DW-1:0] - HI_FIX) : mid[DW-1:0];
    res_o     = (late_fix_i && lo_borrow) ? (stage - END_FIX) : stage;
  end
endmodule

// File: rtl/dau_out_stage.sv
module dau_out_stage
  import dau_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] res_i,
  input  flags_t        flags_i,
  output logic [DW-1:0] res_o,
  output flags_t        flags_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o   <= '0;
        flags_o <= '0;
      end else begin
        res_o   <= res_i;
        flags_o <= flags_i;
      end
    end

    p_lag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (res_o == $past(res_i) && flags_o == $past(flags_i)));
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign res_o   = res_i;
    assign flags_o = flags_i;
  end
endmodule

// File: rtl/dec_arith_unit.sv
module dec_arith_unit
  import dau_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       carry_i,
  input  logic       sub_i,
  input  logic       dec_i,
  input  logic [1:0] variant_i,
  output logic [7:0] result_o,
  output logic       flag_n_o,
  output logic       flag_v_o,
  output logic       flag_z_o,
  output logic       flag_c_o
);
  variant_e      vsel;
  logic          nmos_like;
  logic          late_fix;
  logic [DW-1:0] bin_res, add_res, sub_res, nxt_res, q_res;
  flags_t        bin_flags, nxt_flags, q_flags;
  logic          add_carry, add_mid_n, add_mid_v;

  assign vsel      = variant_e'(variant_i);
  assign nmos_like = (vsel == VAR_NMOS) || (vsel == VAR_ALT);
  assign late_fix  = (vsel == VAR_CMOS);

  dau_bin u_bin (
    .a_i(a_i), .b_i(b_i), .ci_i(carry_i), .sub_i(sub_i),
    .res_o(bin_res), .flags_o(bin_flags)
  );

  dau_dec_add u_dec_add (
    .a_i(a_i), .b_i(b_i), .ci_i(carry_i),
    .res_o(add_res), .carry_o(add_carry), .mid_n_o(add_mid_n), .mid_v_o(add_mid_v)
  );

  dau_dec_sub u_dec_sub (
    .a_i(a_i), .b_i(b_i), .ci_i(carry_i), .late_fix_i(late_fix),
    .res_o(sub_res)
  );

  always_comb begin
    nxt_res   = bin_res;
    nxt_flags = bin_flags;
    if (dec_i) begin
      if (!sub_i) begin
        nxt_res     = add_res;
        nxt_flags.c = add_carry;
        if (nmos_like) begin
          nxt_flags.n = add_mid_n;
          nxt_flags.v = add_mid_v;
          nxt_flags.z = bin_flags.z;
        end else begin
          nxt_flags.n = add_res[DW-1];
          nxt_flags.v = bin_flags.v;
          nxt_flags.z = (add_res == '0);
        end
      end else begin
        nxt_res = sub_res;
        if (!nmos_like) begin
          nxt_flags.n = sub_res[DW-1];
          nxt_flags.z = (sub_res == '0);
        end
      end
    end
  end

  dau_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .res_i(nxt_res), .flags_i(nxt_flags),
    .res_o(q_res), .flags_o(q_flags)
  );

  assign result_o = q_res;
  assign flag_n_o = q_flags.n;
  assign flag_v_o = q_flags.v;
  assign flag_z_o = q_flags.z;
  assign flag_c_o = q_flags.c;

  p_bin_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !sub_i && !carry_i && b_i == 8'h00) |->
      (nxt_res == a_i && !nxt_flags.c && !nxt_flags.v));

  p_sub_noborrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && sub_i && carry_i && b_i == 8'h00) |-> (nxt_res == a_i && nxt_flags.c));

  p_bcd_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !sub_i && a_i[3:0] < 4'd10 && a_i[7:4] < 4'd10 &&
     b_i[3:0] < 4'd10 && b_i[7:4] < 4'd10) |->
      (nxt_res[3:0] < 4'd10 && nxt_res[7:4] < 4'd10));

  p_nmos_sub_z_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && sub_i && carry_i && (variant_i == 2'd0 || variant_i == 2'd3)) |->
      (nxt_flags.z == (a_i == b_i)));

  p_cmos_nz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && variant_i == 2'd1) |->
      (nxt_flags.z == (nxt_res == 8'h00) && nxt_flags.n == nxt_res[7]));
endmodule

// File: tb/dec_arith_unit_bench.sv
`timescale 1ns/1ps
module dec_arith_unit_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a = 8'h00, b = 8'h00;
  logic       c = 1'b0, s = 1'b0, d = 1'b0;
  logic [1:0] vr = 2'd0;
  logic [7:0] r_res, k_res;
  logic       r_n, r_v, r_z, r_c, k_n, k_v, k_z, k_c;
  int         tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  dec_arith_unit #(.REG_OUT(1'b1)) u_dec_arith_unit (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .carry_i(c), .sub_i(s), .dec_i(d),
    .variant_i(vr), .result_o(r_res), .flag_n_o(r_n), .flag_v_o(r_v), .flag_z_o(r_z),
    .flag_c_o(r_c)
  );

  dec_arith_unit #(.REG_OUT(1'b0)) u_dec_arith_unit_comb (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .carry_i(c), .sub_i(s), .dec_i(d),
    .variant_i(vr), .result_o(k_res), .flag_n_o(k_n), .flag_v_o(k_v), .flag_z_o(k_z),
    .flag_c_o(k_c)
  );

  // packed as {result, N, V, Z, C}
  function automatic logic [11:0] ref_calc(logic [7:0] ia, logic [7:0] ib, logic ic,
                                           logic is, logic id, logic [1:0] iv);
    int bs, sr, sa, sb, lo, im;
    logic [7:0] rr;
    logic bn, bv, bz, bc, mn, mv, cf, lb, nm, cm;
    nm = (iv == 2'd0) || (iv == 2'd3);
    cm = (iv == 2'd1);
    sa = ia[7] ? int'(ia) - 256 : int'(ia);
    sb = ib[7] ? int'(ib) - 256 : int'(ib);
    if (!is) begin
      bs = int'(ia) + int'(ib) + int'(ic);
      sr = sa + sb + int'(ic);
    end else begin
      bs = int'(ia) + 255 - int'(ib) + int'(ic);
      sr = sa - sb - (1 - int'(ic));
    end
    rr = bs[7:0]; bc = (bs > 255); bv = (sr > 127) || (sr < -128);
    bn = rr[7]; bz = (rr == 8'h00);
    if (!id) return {rr, bn, bv, bz, bc};
    if (!is) begin
      lo = int'(ia[3:0]) + int'(ib[3:0]) + int'(ic);
      im = (int'(ia) & 240) + (int'(ib) & 240);
      if (lo >= 10) im = im + ((lo + 6) & 15) + 16;
      else im = im + lo;
      mn = im[7];
      mv = (((int'(ia) ^ im) & (int'(ib) ^ im) & 128) != 0);
      cf = 1'b0;
      if (im >= 160) begin im = im + 96; cf = 1'b1; end
      rr = im[7:0];
      if (nm) return {rr, mn, mv, bz, cf};
      return {rr, rr[7], bv, rr == 8'h00, cf};
    end
    lo = int'(ia[3:0]) - int'(ib[3:0]) - (1 - int'(ic));
    lb = (lo < 0);
    if (lb && !cm) lo = (lo - 6) & 15;
    else lo = lo & 15;
    im = (int'(ia) & 240) + lo - (int'(ib) & 240) - (lb ? 16 : 0);
    if (im < 0) im = im - 96;
    if (cm && lb) im = im - 6;
    rr = im[7:0];
    if (nm) return {rr, bn, bv, bz, bc};
    return {rr, rr[7], bv, rr == 8'h00, bc};
  endfunction

  task automatic check(string req, logic [11:0] got, logic [11:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h c=%0d sub=%0d dec=%0d var=%0d)",
               req, got, exp, a, b, c, s, d, vr);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // one vector: combinational copy checked in-cycle, registered copy after the edge
  task automatic run_vec(string req, logic [7:0] ia, logic [7:0] ib, logic ic, logic is,
                         logic id, logic [1:0] iv, logic use_hard, logic [11:0] hard);
    logic [11:0] exp;
    @(negedge clk);
    a = ia; b = ib; c = ic; s = is; d = id; vr = iv;
    exp = use_hard ? hard : ref_calc(ia, ib, ic, is, id, iv);
    #1;
    check(req, {k_res, k_n, k_v, k_z, k_c}, exp);
    @(posedge clk);
    #1;
    check({req, "/R11"}, {r_res, r_n, r_v, r_z, r_c}, exp);
  endtask

  function automatic string tag_for(logic is, logic id, logic [1:0] iv);
    if (!id) return is ? "R2" : "R1";
    if (iv == 2'd3) return "R10";
    if (iv == 2'd0) return is ? "R8" : "R5";
    if (iv == 2'd1 && is) return "R7";
    return "R9";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] e0, e3;
    void'($urandom(32'd20151021));
    a = 8'h5A; b = 8'h33; c = 1'b1; d = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset", {r_res, r_n, r_v, r_z, r_c}, 12'h000);
    @(negedge clk); rst_ni = 1'b1;

    // directed corners, expected values worked out by hand
    run_vec("R1", 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, {8'h80, 4'b1100});
    run_vec("R1", 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, {8'h00, 4'b0011});
    run_vec("R2", 8'h00, 8'h01, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, {8'hFF, 4'b1000});
    run_vec("R2", 8'h80, 8'h01, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, {8'h7F, 4'b0101});
    run_vec("R3", 8'h09, 8'h01, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, {8'h10, 4'b0000});
    run_vec("R4 R5", 8'h99, 8'h01, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, {8'h00, 4'b1001});
    run_vec("R4 R9", 8'h99, 8'h01, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, {8'h00, 4'b0011});
    run_vec("R3 invalid", 8'h0F, 8'h0F, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, {8'h14, 4'b0000});
    run_vec("R6", 8'h10, 8'h01, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, {8'h09, 4'b0001});
    run_vec("R7", 8'h10, 8'h01, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1, {8'h09, 4'b0001});
    run_vec("R6 R8", 8'h00, 8'h01, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, {8'h99, 4'b1000});
    run_vec("R6 R9", 8'h00, 8'h01, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, {8'h99, 4'b1000});
    run_vec("R8", 8'h42, 8'h42, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, {8'h00, 4'b0011});

    // R10: variant 3 and variant 0 compared directly at the ports
    for (int i = 0; i < 200; i++) begin
      logic [7:0] ra, rb;
      logic rc, rs;
      ra = 8'($urandom); rb = 8'($urandom); rc = 1'($urandom); rs = 1'($urandom);
      @(negedge clk); a = ra; b = rb; c = rc; s = rs; d = 1'b1; vr = 2'd0;
      #1; e0 = {k_res, k_n, k_v, k_z, k_c};
      vr = 2'd3;
      #1; e3 = {k_res, k_n, k_v, k_z, k_c};
      check("R10", e3, e0);
    end

    for (int i = 0; i < 40000; i++) begin
      logic [7:0] ra, rb;
      logic rc, rs, rd;
      logic [1:0] rv;
      ra = 8'($urandom); rb = 8'($urandom); rc = 1'($urandom); rs = 1'($urandom);
      rd = ($urandom % 4) != 0;
      rv = 2'($urandom);
      run_vec(tag_for(rs, rd, rv), ra, rb, rc, rs, rd, rv, 1'b0, 12'h000);
    end
    finish_run();
  end
endmodule